// File: doc/BRIEF.md
# Floating-Point Coprocessor Memory Transfer Sequencer

This block turns one floating-point coprocessor data-transfer instruction word into a series of single-word memory accesses. A host presents the instruction together with the current value of the base integer register through a start handshake. The block then works out three things: how many words the instruction moves, the address of the first word, and the updated base address. It issues one memory beat per word over a valid/ready request port. Each beat carries the word address, a load or store flag, and the floating-point register that the word belongs to.

There are two instruction forms. The single-register form moves one value, and its length is set by a precision code. The multiple-register form moves whole registers of three words each, taking consecutive register numbers. When the last beat has been taken, the block raises a one-cycle done pulse. If the instruction asked for base writeback, the updated base value and the base register number are presented with that pulse.

Top module: `fpx_xfer_seq`

## Requirements
- R1: An instruction is accepted on a clock edge where `start_valid` and `start_ready` are both high. `start_ready` stays low from acceptance until the cycle after the done pulse, and `start_valid` has no effect while it is low.
- R2: The offset in instruction bits 7:0 counts words, so the byte displacement is offset×4. Bit 23 = 1 adds the displacement to the base and bit 23 = 0 subtracts it, modulo 2^32. Bit 24 = 1 starts the first beat at the updated base; bit 24 = 0 starts it at the unmodified base.
- R3: Beats go out at ascending word addresses, each 4 bytes above the previous one. While `beat_valid` is high and `beat_ready` is low, the address, register and direction of the beat stay unchanged.
- R4: Instruction bit 20 = 1 makes every beat a load (`beat_load` = 1). Bit 20 = 0 makes every beat a store.
- R5: When bits 11:8 equal 1 (single form), the two-bit code {bit 22, bit 15} sets the beat count: 00 gives 1 beat, 01 gives 2 and 10 gives 3. Every beat names the register in bits 14:12.
- R6: In the single form, code 11 gives 3 beats when `pack_wide` is 0 and 4 beats when it is 1. `pack_wide` is sampled at acceptance.
- R7: When bits 11:8 equal 2 (multiple form), the same code gives the register count: 01 is 1 register, 10 is 2, 11 is 3 and 00 is 4. Each register takes 3 consecutive beats. The register number starts at bits 14:12 and increases by one, modulo 8, every 3 beats.
- R8: `done` is high for exactly one cycle: the cycle right after the edge on which the last beat was accepted.
- R9: With bit 21 set, `wb_valid` is high together with `done`, `wb_base` holds the updated base and `wb_reg` holds bits 19:16. With bit 21 clear, `wb_valid` stays low.
- R10: An instruction whose bits 11:8 are neither 1 nor 2 issues no beats and no writeback. `done` pulses in the cycle after acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_valid | input | 1 | Instruction offered |
| start_ready | output | 1 | Block idle, instruction can be taken |
| start_insn | input | 32 | Transfer instruction word |
| start_base | input | 32 | Current base register value |
| pack_wide | input | 1 | Status flag selecting the 4-word packed format |
| beat_valid | output | 1 | Memory beat request valid |
| beat_ready | input | 1 | Memory accepts the beat |
| beat_addr | output | 32 | Byte address of the word |
| beat_load | output | 1 | 1 = load, 0 = store |
| beat_reg | output | 3 | Floating-point register of this word |
| done | output | 1 | One-cycle completion pulse |
| wb_valid | output | 1 | Base writeback requested, valid with done |
| wb_base | output | 32 | Updated base value |
| wb_reg | output | 4 | Base register number to update |

## Verification
The hardest case to reach is a register-number wrap in the multiple form while the memory side is stalling. Two conditions must hold at once: the register index has to roll from 7 to 0 in the middle of an instruction, and `beat_ready` has to drop on a beat that sits on the three-word register boundary. The stimulus reaches this by starting four-register transfers at registers 6 and 7 while `beat_ready` follows a stall pattern whose period does not divide 3, so stalls land on every word position. During one such stalled transfer, a competing `start_valid` is also held high to confirm that it is ignored.

// File: rtl/fpx_xfer_pkg.sv
package fpx_xfer_pkg;

    localparam int INSN_W = 32;
    localparam int FREG_W = 3;
    localparam int BREG_W = 4;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_BEAT = 2'd1,
        ST_FIN  = 2'd2
    } xfer_state_e;

    typedef enum logic [1:0] {
        FORM_NONE   = 2'd0,
        FORM_SINGLE = 2'd1,
        FORM_MULTI  = 2'd2
    } xfer_form_e;

endpackage

// File: rtl/fpx_xfer_decode.sv
module fpx_xfer_decode
    import fpx_xfer_pkg::*;
#(
    parameter int ADDR_W        = 32,
    parameter int WORDS_PER_REG = 3,
    parameter int CNT_W         = 4
) (
    input  logic [INSN_W-1:0] insn,
    input  logic [ADDR_W-1:0] base,
    input  logic              pack_wide,
    output xfer_form_e        form,
    output logic [CNT_W-1:0]  beats,
    output logic [ADDR_W-1:0] first_addr,
    output logic [ADDR_W-1:0] new_base,
    output logic              is_load,
    output logic              wb_req,
    output logic [FREG_W-1:0] first_reg,
    output logic [BREG_W-1:0] base_reg
);

    logic [1:0]        len_code;
    logic [ADDR_W-1:0] disp;
    logic [2:0]        reg_cnt;

    always_comb begin
        len_code   = {insn[22], insn[15]};
        disp       = ADDR_W'({insn[7:0], 2'b00});
        new_base   = insn[23] ? (base + disp) : (base - disp);
        first_addr = insn[24] ? new_base : base;
        is_load    = insn[20];
        wb_req     = insn[21];
        first_reg  = insn[14:12];
        base_reg   = insn[19:16];
        reg_cnt    = (len_code == 2'b00) ? 3'd4 : {1'b0, len_code};

        unique case (insn[11:8])
            4'd1:    form = FORM_SINGLE;
            4'd2:    form = FORM_MULTI;
            default: form = FORM_NONE;
        endcase

        unique case (form)
            FORM_SINGLE: begin
                unique case (len_code)
                    2'b00:   beats = CNT_W'(1);
                    2'b01:   beats = CNT_W'(2);
                    2'b10:   beats = CNT_W'(3);
                    default: beats = pack_wide ? CNT_W'(4) : CNT_W'(3);
                endcase
            end
            FORM_MULTI: beats = CNT_W'(int'(reg_cnt) * WORDS_PER_REG);
            default:    beats = '0;
        endcase
    end

endmodule

// File: rtl/fpx_xfer_seq.sv
module fpx_xfer_seq
    import fpx_xfer_pkg::*;
#(
    parameter int ADDR_W        = 32,
    parameter int WORDS_PER_REG = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_valid,
    output logic              start_ready,
    input  logic [31:0]       start_insn,
    input  logic [ADDR_W-1:0] start_base,
    input  logic              pack_wide,
    output logic              beat_valid,
    input  logic              beat_ready,
    output logic [ADDR_W-1:0] beat_addr,
    output logic              beat_load,
    output logic [2:0]        beat_reg,
    output logic              done,
    output logic              wb_valid,
    output logic [ADDR_W-1:0] wb_base,
    output logic [3:0]        wb_reg
);

    localparam int MAX_BEATS = WORDS_PER_REG * 4;
    localparam int CNT_W     = $clog2(MAX_BEATS + 1);
    localparam int WD_W      = (WORDS_PER_REG > 1) ? $clog2(WORDS_PER_REG) : 1;
    localparam int STEP      = 4;

    typedef struct packed {
        xfer_state_e       st;
        logic [ADDR_W-1:0] addr;
        logic              load;
        logic [FREG_W-1:0] freg;
        logic [WD_W-1:0]   word;
        logic [CNT_W-1:0]  left;
        logic              multi;
        logic              wb_en;
        logic [ADDR_W-1:0] wb_base;
        logic [BREG_W-1:0] wb_reg;
    } seq_state_t;

    seq_state_t state_d, state_q;

    xfer_form_e        dec_form;
    logic [CNT_W-1:0]  dec_beats;
    logic [ADDR_W-1:0] dec_first, dec_new_base;
    logic              dec_load, dec_wb;
    logic [FREG_W-1:0] dec_reg;
    logic [BREG_W-1:0] dec_base_reg;

    fpx_xfer_decode #(
        .ADDR_W       (ADDR_W),
        .WORDS_PER_REG(WORDS_PER_REG),
        .CNT_W        (CNT_W)
    ) u_decode (
        .insn      (start_insn),
        .base      (start_base),
        .pack_wide (pack_wide),
        .form      (dec_form),
        .beats     (dec_beats),
        .first_addr(dec_first),
        .new_base  (dec_new_base),
        .is_load   (dec_load),
        .wb_req    (dec_wb),
        .first_reg (dec_reg),
        .base_reg  (dec_base_reg)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q.st)
            ST_IDLE: begin
                if (start_valid) begin
                    state_d.addr    = dec_first;
                    state_d.load    = dec_load;
                    state_d.freg    = dec_reg;
                    state_d.word    = '0;
                    state_d.left    = dec_beats;
                    state_d.multi   = (dec_form == FORM_MULTI);
                    state_d.wb_en   = dec_wb && (dec_form != FORM_NONE);
                    state_d.wb_base = dec_new_base;
                    state_d.wb_reg  = dec_base_reg;
                    state_d.st      = (dec_form == FORM_NONE) ? ST_FIN : ST_BEAT;
                end
            end
            ST_BEAT: begin
                if (beat_ready) begin
                    state_d.addr = state_q.addr + ADDR_W'(STEP);
                    state_d.left = state_q.left - 1'b1;
                    if (state_q.multi) begin
                        if (state_q.word == WD_W'(WORDS_PER_REG - 1)) begin
                            state_d.word = '0;
                            state_d.freg = state_q.freg + 1'b1;
                        end else begin
                            state_d.word = state_q.word + 1'b1;
                        end
                    end
                    if (state_q.left == CNT_W'(1)) begin
                        state_d.st = ST_FIN;
                    end
                end
            end
            ST_FIN:  state_d.st = ST_IDLE;
            default: state_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= '0;
            state_q.st <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    assign start_ready = (state_q.st == ST_IDLE);
    assign beat_valid  = (state_q.st == ST_BEAT);
    assign beat_addr   = state_q.addr;
    assign beat_load   = state_q.load;
    assign beat_reg    = state_q.freg;
    assign done        = (state_q.st == ST_FIN);
    assign wb_valid    = done && state_q.wb_en;
    assign wb_base     = state_q.wb_base;
    assign wb_reg      = state_q.wb_reg;

    assert_busy_blocks_start_R1: assert property (@(posedge clk) disable iff (!rst_n)
        beat_valid |-> !start_ready);

    assert_beat_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        beat_valid && !beat_ready |=> beat_valid && $stable(beat_addr)
                                      && $stable(beat_reg) && $stable(beat_load));

    assert_beat_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        beat_valid && beat_ready && !$past(start_ready) && (state_q.left != CNT_W'(1))
        |=> beat_valid && (beat_addr == $past(beat_addr) + ADDR_W'(STEP)));

    assert_dir_fixed_R4: assert property (@(posedge clk) disable iff (!rst_n)
        beat_valid && beat_ready && (state_q.left != CNT_W'(1)) |=> $stable(beat_load));

    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_wb_with_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |-> done);

    assert_no_beats_R10: assert property (@(posedge clk) disable iff (!rst_n)
        start_valid && start_ready && (start_insn[11:8] != 4'd1) && (start_insn[11:8] != 4'd2)
        |=> done && !beat_valid && !wb_valid);

endmodule

// File: tb/fpx_xfer_seq_test.sv
module fpx_xfer_seq_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_valid = 1'b0;
    logic        start_ready;
    logic [31:0] start_insn = '0;
    logic [31:0] start_base = '0;
    logic        pack_wide = 1'b0;
    logic        beat_valid;
    logic        beat_ready = 1'b0;
    logic [31:0] beat_addr;
    logic        beat_load;
    logic [2:0]  beat_reg;
    logic        done;
    logic        wb_valid;
    logic [31:0] wb_base;
    logic [3:0]  wb_reg;

    int checks = 0;
    int errors = 0;
    int ready_mode = 0;
    bit exp_done_now = 0;

    typedef struct {
        logic [31:0] addr;
        logic        ld;
        logic [2:0]  r;
        bit          last;
    } beat_t;

    typedef struct {
        logic        wb;
        logic [31:0] nb;
        logic [3:0]  rn;
    } fin_t;

    beat_t beat_q[$];
    fin_t  fin_q[$];

    always #5 clk = ~clk;

    fpx_xfer_seq uut (
        .clk(clk), .rst_n(rst_n),
        .start_valid(start_valid), .start_ready(start_ready),
        .start_insn(start_insn), .start_base(start_base), .pack_wide(pack_wide),
        .beat_valid(beat_valid), .beat_ready(beat_ready),
        .beat_addr(beat_addr), .beat_load(beat_load), .beat_reg(beat_reg),
        .done(done), .wb_valid(wb_valid), .wb_base(wb_base), .wb_reg(wb_reg)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(input int cp, input bit pre, input bit up,
                                       input bit wb, input bit ld, input logic [1:0] code,
                                       input logic [3:0] rn, input logic [2:0] fd,
                                       input logic [7:0] off);
        logic [31:0] w;
        w = 32'hEC00_0000;
        w[24] = pre; w[23] = up; w[22] = code[1]; w[21] = wb; w[20] = ld;
        w[19:16] = rn; w[15] = code[0]; w[14:12] = fd;
        w[11:8] = 4'(cp); w[7:0] = off;
        return w;
    endfunction

    // Scoreboard producer: expected beats and completion from the requirements.
    task automatic predict(input logic [31:0] insn, input logic [31:0] base, input bit ew);
        logic [31:0] disp, nb, st;
        logic [1:0]  code;
        int n;
        bit multi;
        disp  = {22'd0, insn[7:0], 2'b00};
        nb    = insn[23] ? base + disp : base - disp;   // R2
        st    = insn[24] ? nb : base;
        code  = {insn[22], insn[15]};
        multi = (insn[11:8] == 4'd2);
        if (insn[11:8] == 4'd1)
            n = (code == 2'b11) ? (ew ? 4 : 3) : int'(code) + 1;   // R5 R6
        else if (multi)
            n = 3 * ((code == 2'b00) ? 4 : int'(code));          // R7
        else
            n = 0;                                               // R10
        for (int k = 0; k < n; k++) begin
            beat_t b;
            b.addr = st + 32'(4 * k);
            b.ld   = insn[20];
            b.r    = multi ? insn[14:12] + 3'(k / 3) : insn[14:12];
            b.last = (k == n - 1);
            beat_q.push_back(b);
        end
        begin
            fin_t f;
            f.wb = insn[21] && (n > 0);
            f.nb = nb;
            f.rn = insn[19:16];
            fin_q.push_back(f);
        end
    endtask

    task automatic launch(input logic [31:0] insn, input logic [31:0] base, input bit ew);
        @(negedge clk);
        while (!start_ready) @(negedge clk);
        predict(insn, base, ew);
        start_insn  = insn;
        start_base  = base;
        pack_wide   = ew;
        start_valid = 1'b1;
        @(negedge clk);
        start_valid = 1'b0;
        pack_wide   = ~ew;
        start_base  = 32'hDEAD_BEEF;
    endtask

    task automatic finish_wait();
        while (fin_q.size() != 0) @(negedge clk);
    endtask

    task automatic run(input logic [31:0] insn, input logic [31:0] base, input bit ew);
        launch(insn, base, ew);
        finish_wait();
    endtask

    // Memory-side ready pattern, changed just after each rising edge.
    initial begin
        int cnt = 0;
        forever begin
            @(posedge clk);
            #1;
            cnt++;
            case (ready_mode)
                0:       beat_ready = 1'b1;
                1:       beat_ready = (cnt % 4) != 1;
                default: beat_ready = (cnt % 7) >= 3;
            endcase
        end
    end

    // Scoreboard consumer.
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n) begin
                if (exp_done_now) begin
                    check(done === 1'b1, "R8 done after last beat", 32'(done), 32'd1);
                    exp_done_now = 0;
                end
                if (beat_valid)
                    check(start_ready === 1'b0, "R1 ready low while busy", 32'(start_ready), 32'd0);
                if (beat_valid && beat_ready) begin
                    if (beat_q.size() == 0) begin
                        check(1'b0, "R10 unexpected beat", beat_addr, 32'd0);
                    end else begin
                        beat_t e;
                        e = beat_q.pop_front();
                        check(beat_addr === e.addr, "R2 R3 beat address", beat_addr, e.addr);
                        check(beat_load === e.ld, "R4 beat direction", 32'(beat_load), 32'(e.ld));
                        check(beat_reg === e.r, "R5 R7 beat register", 32'(beat_reg), 32'(e.r));
                        if (e.last) exp_done_now = 1;
                    end
                end
                if (done) begin
                    check(beat_q.size() == 0, "R8 done before all beats", 32'(beat_q.size()), 32'd0);
                    if (fin_q.size() == 0) begin
                        check(1'b0, "R8 unexpected done", 32'd1, 32'd0);
                    end else begin
                        fin_t f;
                        f = fin_q.pop_front();
                        check(wb_valid === f.wb, "R9 R10 writeback flag", 32'(wb_valid), 32'(f.wb));
                        if (f.wb) begin
                            check(wb_base === f.nb, "R9 writeback base", wb_base, f.nb);
                            check(wb_reg === f.rn, "R9 writeback register", 32'(wb_reg), 32'(f.rn));
                        end
                    end
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        check(1'b0, "watchdog expired", 32'd0, 32'd1);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(start_ready === 1'b1, "R1 reset ready", 32'(start_ready), 32'd1);
        check(beat_valid === 1'b0, "R3 reset no beat", 32'(beat_valid), 32'd0);
        check(done === 1'b0, "R8 reset no done", 32'(done), 32'd0);
        rst_n = 1'b1;

        // Single form, each precision, full ready.
        run(mk(1, 1, 1, 1, 1, 2'b00, 4'd3, 3'd2, 8'd5), 32'h0000_1000, 1'b0);   // R5
        run(mk(1, 0, 0, 1, 0, 2'b01, 4'd9, 3'd7, 8'd3), 32'h0000_2000, 1'b0);   // R2 post/down
        run(mk(1, 1, 0, 0, 1, 2'b10, 4'd1, 3'd0, 8'd2), 32'h0000_3000, 1'b0);   // R9 no wb
        run(mk(1, 1, 1, 1, 0, 2'b11, 4'd4, 3'd5, 8'd1), 32'h0000_4000, 1'b0);   // R6 narrow
        run(mk(1, 1, 1, 1, 0, 2'b11, 4'd4, 3'd5, 8'd1), 32'h0000_4000, 1'b1);   // R6 wide

        // Boundary offsets: largest offset, wrap below zero.
        run(mk(1, 1, 1, 1, 1, 2'b01, 4'd15, 3'd1, 8'hFF), 32'hFFFF_FF00, 1'b0); // R2
        run(mk(1, 1, 0, 1, 1, 2'b00, 4'd0, 3'd1, 8'h10), 32'h0000_0010, 1'b0);  // R2

        // Multiple form, all counts, with stalls and wrap.
        ready_mode = 1;
        run(mk(2, 1, 1, 1, 1, 2'b01, 4'd6, 3'd4, 8'd3), 32'h0000_5000, 1'b0);   // R7 one reg
        run(mk(2, 0, 1, 1, 0, 2'b10, 4'd6, 3'd7, 8'd6), 32'h0000_6000, 1'b0);   // R7 wrap
        run(mk(2, 1, 0, 1, 1, 2'b11, 4'd2, 3'd6, 8'd9), 32'h0000_7000, 1'b0);   // R7 three
        ready_mode = 2;
        run(mk(2, 0, 0, 1, 0, 2'b00, 4'd13, 3'd6, 8'd12), 32'h0000_8000, 1'b0); // R7 four
        run(mk(1, 0, 1, 1, 1, 2'b11, 4'd5, 3'd3, 8'd4), 32'h0000_9000, 1'b1);   // R3 stall

        // Competing start while busy must be ignored (R1).
        launch(mk(2, 1, 1, 1, 1, 2'b00, 4'd8, 3'd7, 8'd1), 32'h0000_A000, 1'b0);
        for (int i = 0; i < 4; i++) begin
            start_insn  = mk(1, 1, 1, 1, 0, 2'b00, 4'd1, 3'd1, 8'd0);
            start_base  = 32'h1234_0000;
            start_valid = 1'b1;
            @(negedge clk);
            check(start_ready === 1'b0, "R1 start ignored while busy", 32'(start_ready), 32'd0);
        end
        start_valid = 1'b0;
        finish_wait();

        // Other coprocessor numbers: no beats (R10).
        ready_mode = 0;
        run(mk(3, 1, 1, 1, 1, 2'b00, 4'd2, 3'd2, 8'd4), 32'h0000_B000, 1'b0);
        run(mk(0, 0, 0, 1, 0, 2'b11, 4'd7, 3'd0, 8'd8), 32'h0000_C000, 1'b1);
        run(mk(1, 1, 1, 0, 1, 2'b00, 4'd2, 3'd2, 8'd0), 32'h0000_D000, 1'b0);

        repeat (4) @(negedge clk);
        check(beat_q.size() == 0, "R3 all beats issued", 32'(beat_q.size()), 32'd0);
        check(start_ready === 1'b1, "R1 idle at end", 32'(start_ready), 32'd1);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule